// File: doc/BRIEF.md
# DDR SDRAM Refresh Command Sequencer

This block sits inside a DDR SDRAM memory controller and owns every command that keeps the memory's contents alive. A free-running interval counter marks a refresh as owed once per refresh interval. Owed refreshes are allowed to pile up to a parameterised limit. When the limit is reached, the sequencer closes any open banks and issues the owed auto-refresh commands back to back, each spaced by the refresh cycle time. While it works, it drives NOP and lowers its "command allowed" flag so the scheduler stays off the bus.

The scheduler can also request self-refresh entry and exit over a request/acknowledge pair. Entry closes open banks and issues an auto-refresh with CKE low in the same cycle. The device then rests with CKE low and the command bus inhibited. Exit waits for the clock-stable flag before raising CKE, then drives NOPs for the exit time before ordinary commands are allowed again. READ has its own gate: after exit the block pulses a DLL-reset request to the mode-register logic, and READ stays forbidden until the lock time has passed after that pulse. All timings are parameters in clock cycles.

Top module: `ddr_refresh_seq`

## Requirements
- R1: When a sequence starts and two or more bits of `bankOpen` are set, the block first drives PRECHARGE ({csN,rasN,casN,weN}=0010) with `addrAp`=1. When exactly one bit is set, the PRECHARGE has `addrAp`=0 and `bankAddr` equal to that bit's index. When no bit is set, no PRECHARGE is issued and the cycle before the refresh command is NOP.
- R2: The refresh command (0010 is precharge; refresh is 0001) follows a PRECHARGE by exactly TRP cycles.
- R3: For the TRFC-1 cycles after an auto-refresh command that keeps CKE high, the bus carries NOP (0111) and `cmdAllowed` is low.
- R4: CKE stays high from an auto-refresh command until TRFC cycles have passed.
- R5: Owed refreshes in one burst are issued exactly TRFC cycles apart.
- R6: One refresh becomes owed every TREFI cycles. A burst starts when MAX_PEND are owed and issues exactly MAX_PEND refreshes. Bursts without precharge therefore start MAX_PEND*TREFI cycles apart. `cmdAllowed` returns high TRFC cycles after the last refresh.
- R7: On `srEnterReq`, after any precharge (R1), the refresh command is issued with CKE low. In the next cycle `srAck` pulses for one cycle. CKE then stays low, `csN`=1 (inhibit), and both allowed flags are low.
- R8: While in self refresh, CKE stays low until `srExitReq` and `clkStable` are both high at a clock edge. CKE goes high in the cycle after that edge.
- R9: From the first cycle with CKE high, the bus carries NOP for TXSNR cycles. On the next cycle `cmdAllowed` rises and `srAck` pulses.
- R10: `dllRstReq` pulses exactly once, TXSRD cycles after CKE rises. `readAllowed` stays low until exactly DLL_LOCK cycles after that pulse.
- R11: Out of reset, CKE is high, the bus carries NOP, `cmdAllowed` and `readAllowed` are high, and `srAck` and `dllRstReq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| srEnterReq | input | 1 | Scheduler request to enter self refresh, held until `srAck` |
| srExitReq | input | 1 | Scheduler request to leave self refresh, held until `srAck` |
| srAck | output | 1 | One-cycle acknowledge when a requested sequence is complete |
| clkStable | input | 1 | Memory clock has been stable long enough to raise CKE |
| bankOpen | input | NBANK | One bit per bank, set while that bank has an open row |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| addrAp | output | 1 | Address bit 10: all-bank select during precharge |
| bankAddr | output | $clog2(NBANK) | Bank address for a single-bank precharge |
| cke | output | 1 | Clock enable to the memory |
| cmdAllowed | output | 1 | Scheduler may issue non-READ commands this cycle |
| readAllowed | output | 1 | Scheduler may issue READ this cycle |
| dllRstReq | output | 1 | One-cycle request to the mode-register logic for a DLL reset |

## Verification
Some properties are checked by assertions on every cycle. These are the refresh spacing and the quiet bus after each auto refresh (counted with cycle counters beside the control logic), CKE held high through the refresh period, CKE rising only after the clock-stable flag, the bound on owed refreshes, and the READ gate opening only after a DLL-reset pulse. The directed scenarios cover the rest. They show the precharge choice (all banks, one bank, none) and the exact cycle counts of each wait. They also show burst length and burst period from the interval counter, the acknowledge timing, CKE held low while clock-stable is withheld, and the exact cycles of the DLL-reset pulse and the READ release.

// File: rtl/refseq_pkg.sv
package refseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_WRP, ST_AREF, ST_WRFC, ST_SRE, ST_SELF, ST_XNOP
  } seqState_t;

  typedef enum logic [1:0] {TM_RP, TM_RFC, TM_XSNR} timerSel_t;

  typedef struct packed {
    logic      timerLoad;
    timerSel_t timerSel;
    logic      arIssue;
    logic      srEnter;
    logic      srHold;
    logic      exitStart;
  } seqStrobe_t;

  // {csN, rasN, casN, weN}
  localparam logic [3:0] CMD_NOP  = 4'b0111;
  localparam logic [3:0] CMD_INH  = 4'b1111;
  localparam logic [3:0] CMD_PRE  = 4'b0010;
  localparam logic [3:0] CMD_AREF = 4'b0001;

endpackage

// File: rtl/refseq_dpath.sv
module refseq_dpath
  import refseq_pkg::*;
#(
  parameter int TRP      = 3,
  parameter int TRFC     = 9,
  parameter int TXSNR    = 12,
  parameter int TXSRD    = 200,
  parameter int DLL_LOCK = 200,
  parameter int TREFI    = 780,
  parameter int MAX_PEND = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strb,
  output logic       timerZero,
  output logic       pendFull,
  output logic       pendZero,
  output logic       dllLocked,
  output logic       dllRstReq
);

  localparam int TW = $clog2(TRP + TRFC + TXSNR + 1);
  localparam int IW = $clog2(TREFI);
  localparam int PW = $clog2(MAX_PEND + 1);
  localparam int XW = $clog2(TXSRD + DLL_LOCK + 1);

  // wait timer: loaded by control, counts down to zero
  logic [TW-1:0] timer, loadVal;

  always_comb begin
    case (strb.timerSel)
      TM_RP:   loadVal = TW'(TRP - 2);
      TM_RFC:  loadVal = TW'(TRFC - 2);
      default: loadVal = TW'(TXSNR - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)               timer <= '0;
    else if (strb.timerLoad) timer <= loadVal;
    else if (timer != '0)    timer <= timer - 1'b1;
  end
  assign timerZero = (timer == '0);

  // refresh interval and owed-refresh count
  logic [IW-1:0] intCnt;
  logic [PW-1:0] pend, pendNext;
  logic          tick;

  assign tick = !strb.srHold && (intCnt == IW'(TREFI - 1));

  always_ff @(posedge clk) begin
    if (!rstN || strb.srHold) intCnt <= '0;
    else if (tick)            intCnt <= '0;
    else                      intCnt <= intCnt + 1'b1;
  end

  always_comb begin
    int nx;
    nx = int'(pend) + int'(tick) - int'(strb.arIssue);
    if (nx > MAX_PEND) nx = MAX_PEND;
    if (nx < 0)        nx = 0;
    pendNext = PW'(nx);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.srEnter) pend <= '0;
    else                       pend <= pendNext;
  end
  assign pendFull = (pend == PW'(MAX_PEND));
  assign pendZero = (pend == '0);

  // exit tracker: DLL reset request, then lock time before READ
  logic [XW-1:0] xCnt;
  logic          xActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xCnt <= '0; xActive <= 1'b0; dllLocked <= 1'b1;
    end else if (strb.srEnter) begin
      xActive <= 1'b0; dllLocked <= 1'b0;
    end else if (strb.exitStart) begin
      xActive <= 1'b1; xCnt <= '0;
    end else if (xActive) begin
      xCnt <= xCnt + 1'b1;
      if (xCnt == XW'(TXSRD + DLL_LOCK - 1)) begin
        dllLocked <= 1'b1; xActive <= 1'b0;
      end
    end
  end
  assign dllRstReq = xActive && (xCnt == XW'(TXSRD));

  // checker state: a DLL reset has been requested since entry
  logic rstSeen;
  always_ff @(posedge clk) begin
    if (!rstN || strb.srEnter) rstSeen <= 1'b0;
    else if (dllRstReq)        rstSeen <= 1'b1;
  end

  AST_PEND_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    pend <= PW'(MAX_PEND)); // R6
  AST_DLL_AFTER_RST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dllLocked) |-> rstSeen); // R10

endmodule

// File: rtl/refseq_ctrl.sv
module refseq_ctrl
  import refseq_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int TRP   = 3,
  parameter int TRFC  = 9,
  parameter int BW    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srEnterReq,
  input  logic             srExitReq,
  input  logic             clkStable,
  input  logic [NBANK-1:0] bankOpen,
  input  logic             timerZero,
  input  logic             pendFull,
  input  logic             pendZero,
  output seqStrobe_t       strb,
  output logic [3:0]       cmdBus,
  output logic             addrAp,
  output logic [BW-1:0]    bankAddr,
  output logic             cke,
  output logic             cmdAllowed,
  output logic             srAck
);

  localparam int AW = $clog2(TRFC + 1);
  localparam int RW = $clog2(TRP + 1);

  seqState_t st, nxt;
  logic goSr, ackSet, startRef, startSr;
  logic openAny, openMany;
  logic [BW-1:0] openIdx;

  always_comb begin
    int cnt;
    cnt = 0;
    openIdx = '0;
    for (int i = 0; i < NBANK; i++) begin
      if (bankOpen[i]) begin
        cnt++;
        openIdx = BW'(i);
      end
    end
    openAny  = (cnt != 0);
    openMany = (cnt > 1);
  end

  assign startRef = (st == ST_IDLE) && pendFull;
  assign startSr  = (st == ST_IDLE) && srEnterReq && !pendFull;

  always_comb begin
    nxt = st;
    ackSet = 1'b0;
    strb.timerLoad = 1'b0;
    strb.timerSel  = TM_RP;
    strb.arIssue   = 1'b0;
    strb.srEnter   = 1'b0;
    strb.srHold    = 1'b0;
    strb.exitStart = 1'b0;
    case (st)
      ST_IDLE:
        if (startRef || startSr)
          nxt = openAny ? ST_PRE : (startSr ? ST_SRE : ST_AREF);
      ST_PRE: begin
        strb.timerLoad = 1'b1;
        strb.timerSel  = TM_RP;
        nxt = ST_WRP;
      end
      ST_WRP:
        if (timerZero) nxt = goSr ? ST_SRE : ST_AREF;
      ST_AREF: begin
        strb.arIssue   = 1'b1;
        strb.timerLoad = 1'b1;
        strb.timerSel  = TM_RFC;
        nxt = ST_WRFC;
      end
      ST_WRFC:
        if (timerZero) nxt = pendZero ? ST_IDLE : ST_AREF;
      ST_SRE: begin
        strb.srEnter = 1'b1;
        strb.srHold  = 1'b1;
        ackSet = 1'b1;
        nxt = ST_SELF;
      end
      ST_SELF: begin
        strb.srHold = 1'b1;
        if (srExitReq && clkStable) begin
          strb.exitStart = 1'b1;
          strb.timerLoad = 1'b1;
          strb.timerSel  = TM_XSNR;
          nxt = ST_XNOP;
        end
      end
      default:
        if (timerZero) begin
          nxt = ST_IDLE;
          ackSet = 1'b1;
        end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= ST_IDLE; goSr <= 1'b0; srAck <= 1'b0;
    end else begin
      st <= nxt;
      srAck <= ackSet;
      if (startRef || startSr) goSr <= startSr;
    end
  end

  always_comb begin
    cmdBus = CMD_NOP;
    cke = 1'b1;
    addrAp = 1'b0;
    bankAddr = '0;
    case (st)
      ST_PRE: begin
        cmdBus = CMD_PRE;
        addrAp = openMany;
        bankAddr = openMany ? '0 : openIdx;
      end
      ST_AREF: cmdBus = CMD_AREF;
      ST_SRE:  begin cmdBus = CMD_AREF; cke = 1'b0; end
      ST_SELF: begin cmdBus = CMD_INH;  cke = 1'b0; end
      default: ;
    endcase
  end

  assign cmdAllowed = (st == ST_IDLE) && !startRef && !startSr;

  // checker counters: cycles since the last refresh and precharge command
  logic [AW-1:0] arCnt;
  logic [RW-1:0] preCnt;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      arCnt <= AW'(TRFC); preCnt <= RW'(TRP);
    end else begin
      if (cmdBus == CMD_AREF)      arCnt <= '0;
      else if (arCnt < AW'(TRFC))  arCnt <= arCnt + 1'b1;
      if (cmdBus == CMD_PRE)       preCnt <= '0;
      else if (preCnt < RW'(TRP))  preCnt <= preCnt + 1'b1;
    end
  end

  AST_RFC_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (arCnt < AW'(TRFC - 1)) |-> (cmdBus == CMD_NOP || cmdBus[3])); // R3
  AST_RFC_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBus == CMD_AREF) |-> (arCnt >= AW'(TRFC - 1))); // R5
  AST_TRP_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBus == CMD_AREF) |-> (preCnt >= RW'(TRP - 1))); // R2
  AST_CKE_RFC: assert property (@(posedge clk) disable iff (!rstN)
    (arCnt < AW'(TRFC - 1)) && $past(cke) |-> cke); // R4
  AST_CKE_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> $past(clkStable)); // R8
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    srAck |=> !srAck); // R7

endmodule

// File: rtl/ddr_refresh_seq.sv
module ddr_refresh_seq
  import refseq_pkg::*;
#(
  parameter int NBANK    = 4,
  parameter int TRP      = 3,
  parameter int TRFC     = 9,
  parameter int TXSNR    = 12,
  parameter int TXSRD    = 200,
  parameter int DLL_LOCK = 200,
  parameter int TREFI    = 780,
  parameter int MAX_PEND = 4,
  localparam int BW      = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srEnterReq,
  input  logic             srExitReq,
  output logic             srAck,
  input  logic             clkStable,
  input  logic [NBANK-1:0] bankOpen,
  output logic             csN,
  output logic             rasN,
  output logic             casN,
  output logic             weN,
  output logic             addrAp,
  output logic [BW-1:0]    bankAddr,
  output logic             cke,
  output logic             cmdAllowed,
  output logic             readAllowed,
  output logic             dllRstReq
);

  seqStrobe_t strb;
  logic timerZero, pendFull, pendZero, dllLocked;
  logic [3:0] cmdBus;

  refseq_ctrl #(.NBANK(NBANK), .TRP(TRP), .TRFC(TRFC), .BW(BW)) uCtrl (
    .clk(clk), .rstN(rstN), .srEnterReq(srEnterReq), .srExitReq(srExitReq),
    .clkStable(clkStable), .bankOpen(bankOpen), .timerZero(timerZero),
    .pendFull(pendFull), .pendZero(pendZero), .strb(strb), .cmdBus(cmdBus),
    .addrAp(addrAp), .bankAddr(bankAddr), .cke(cke),
    .cmdAllowed(cmdAllowed), .srAck(srAck)
  );

  refseq_dpath #(.TRP(TRP), .TRFC(TRFC), .TXSNR(TXSNR), .TXSRD(TXSRD),
                 .DLL_LOCK(DLL_LOCK), .TREFI(TREFI), .MAX_PEND(MAX_PEND)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .timerZero(timerZero),
    .pendFull(pendFull), .pendZero(pendZero), .dllLocked(dllLocked),
    .dllRstReq(dllRstReq)
  );

  assign {csN, rasN, casN, weN} = cmdBus;
  assign readAllowed = cmdAllowed && dllLocked;

endmodule

// File: tb/sim_ddr_refresh_seq.sv
module sim_ddr_refresh_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NBANK = 4, TRP = 3, TRFC = 8, TXSNR = 10, TXSRD = 20;
  localparam int DLL_LOCK = 200, TREFI = 300, MAX_PEND = 2;
  localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010, C_AR = 4'b0001;

  logic clk = 1'b0, rstN = 1'b0;
  logic srEnterReq = 1'b0, srExitReq = 1'b0, clkStable = 1'b1;
  logic [NBANK-1:0] bankOpen = '0;
  logic srAck, csN, rasN, casN, weN, addrAp, cke, cmdAllowed, readAllowed, dllRstReq;
  logic [1:0] bankAddr;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  ddr_refresh_seq #(.NBANK(NBANK), .TRP(TRP), .TRFC(TRFC), .TXSNR(TXSNR),
    .TXSRD(TXSRD), .DLL_LOCK(DLL_LOCK), .TREFI(TREFI), .MAX_PEND(MAX_PEND)) u0 (
    .clk(clk), .rstN(rstN), .srEnterReq(srEnterReq), .srExitReq(srExitReq),
    .srAck(srAck), .clkStable(clkStable), .bankOpen(bankOpen), .csN(csN),
    .rasN(rasN), .casN(casN), .weN(weN), .addrAp(addrAp), .bankAddr(bankAddr),
    .cke(cke), .cmdAllowed(cmdAllowed), .readAllowed(readAllowed),
    .dllRstReq(dllRstReq));

  function automatic logic [3:0] cmdNow();
    return {csN, rasN, casN, weN};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitCmd(input logic [3:0] code, input int limit,
                         output bit got, output logic [3:0] prev);
    got = 0; prev = cmdNow();
    for (int i = 0; i < limit; i++) begin
      if (cmdNow() == code) begin got = 1; break; end
      prev = cmdNow();
      step();
    end
  endtask

  task automatic testReset();
    check(cke && cmdNow() == C_NOP, "R11 cke/NOP in reset", {cke, cmdNow()}, {1'b1, C_NOP});
    rstN = 1'b1;
    step();
    check(cmdAllowed && readAllowed, "R11 allowed flags", {cmdAllowed, readAllowed}, 3);
    check(!srAck && !dllRstReq, "R11 ack/dll idle", {srAck, dllRstReq}, 0);
  endtask

  task automatic testRefreshOpen();
    bit got, ok, okCke; logic [3:0] prev; int gap;
    bankOpen = 4'b1011;
    waitCmd(C_PRE, 3*TREFI, got, prev);
    check(got, "R1 precharge before refresh", got, 1);
    check(addrAp == 1'b1, "R1 all-bank precharge", addrAp, 1);
    gap = 0;
    do begin step(); gap++; bankOpen = '0; end while (cmdNow() != C_AR && gap < 50);
    check(gap == TRP, "R2 precharge to refresh gap", gap, TRP);
    ok = 1; okCke = 1;
    for (int i = 1; i < TRFC; i++) begin
      step();
      ok &= (cmdNow() == C_NOP) && !cmdAllowed;
      okCke &= cke;
    end
    check(ok, "R3 quiet bus after refresh", ok, 1);
    check(okCke, "R4 cke high in refresh", okCke, 1);
    step();
    check(cmdNow() == C_AR, "R5 back-to-back refresh spacing", cmdNow(), C_AR);
    for (int i = 1; i < TRFC; i++) step();
    step();
    check(cmdAllowed && cmdNow() == C_NOP, "R6 burst ends after MAX_PEND", cmdAllowed, 1);
  endtask

  task automatic testRefreshClosed();
    bit got; logic [3:0] prev; int t1, t2, nAr;
    waitCmd(C_AR, 3*TREFI, got, prev);
    t1 = cyc;
    check(got && prev == C_NOP, "R1 no precharge with banks closed", prev, C_NOP);
    nAr = 1;
    for (int i = 0; i < MAX_PEND*TRFC + 4; i++) begin
      step();
      if (cmdNow() == C_AR) nAr++;
    end
    check(nAr == MAX_PEND, "R6 refreshes per burst", nAr, MAX_PEND);
    waitCmd(C_AR, 3*TREFI, got, prev);
    t2 = cyc;
    check(got && (t2 - t1) == MAX_PEND*TREFI, "R6 burst period", t2 - t1, MAX_PEND*TREFI);
    for (int i = 0; i < 100 && !cmdAllowed; i++) step();
  endtask

  task automatic testSrEntry();
    bit ok; int gap;
    bankOpen = 4'b0100;
    srEnterReq = 1'b1;
    step();
    check(cmdNow() == C_PRE && !addrAp && bankAddr == 2'd2, "R1 single-bank precharge",
          {addrAp, bankAddr}, 2);
    gap = 0;
    do begin step(); gap++; bankOpen = '0; end while (cmdNow() != C_AR && gap < 50);
    check(gap == TRP && !cke, "R7 entry refresh with cke low", {gap, cke}, {TRP, 1'b0});
    step();
    check(srAck && !cke && csN, "R7 entry acknowledge", {srAck, cke, csN}, 5);
    srEnterReq = 1'b0;
    ok = 1;
    for (int i = 0; i < 20; i++) begin
      step();
      ok &= !cke && csN && !cmdAllowed && !readAllowed && !srAck;
    end
    check(ok, "R7 self refresh hold", ok, 1);
  endtask

  task automatic testSrExit();
    bit ok; int firstRst, firstRd, nRst;
    srExitReq = 1'b1; clkStable = 1'b0;
    ok = 1;
    for (int i = 0; i < 15; i++) begin step(); ok &= !cke; end
    check(ok, "R8 cke low without clock stable", ok, 1);
    clkStable = 1'b1;
    step();
    check(cke, "R8 cke rises after clock stable", cke, 1);
    ok = 1;
    for (int i = 0; i < TXSNR; i++) begin
      ok &= (cmdNow() == C_NOP) && !cmdAllowed && cke;
      step();
    end
    check(ok, "R9 NOPs during exit time", ok, 1);
    check(cmdAllowed && srAck, "R9 commands allowed after exit", {cmdAllowed, srAck}, 3);
    check(!readAllowed, "R10 READ still blocked", readAllowed, 0);
    srExitReq = 1'b0;
    firstRst = -1; firstRd = -1; nRst = 0;
    for (int i = TXSNR; i <= TXSRD + DLL_LOCK + 2; i++) begin
      if (dllRstReq) begin nRst++; if (firstRst < 0) firstRst = i; end
      if (readAllowed && firstRd < 0) firstRd = i;
      step();
    end
    check(firstRst == TXSRD && nRst == 1, "R10 DLL reset request timing", firstRst, TXSRD);
    check(firstRd == TXSRD + DLL_LOCK, "R10 READ release timing", firstRd, TXSRD + DLL_LOCK);
  endtask

  initial begin
    repeat (5) step();
    testReset();
    testRefreshOpen();
    testRefreshClosed();
    testSrEntry();
    testSrExit();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule